// File: doc/BRIEF.md
# Multipath Entropy Path Selector

This block keeps a table of entropy values (path identifiers) for one sending connection and picks one healthy entry for every outgoing packet. Traffic is therefore spread over many network paths rather than being pinned to a single one. Each entry has its own health state: GOOD, SKIP or BAD. Congestion feedback parks an entry in SKIP for a few selection rounds. A timeout moves it to BAD. BAD entries are probed periodically, and a successful probe returns them to service. A denylist removes entries from selection no matter what their health state is.

The packet engine raises `req_i` once per packet and takes the chosen index from `sel_idx_o` while `sel_valid_o` is high. Feedback arrives on a single tagged event bus, one event per cycle. Probe requests for BAD entries leave on `probe_o` and `probe_idx_o`, and the probe engine sends back a probe-success event on the same feedback bus.

Top module: `mp_path_sel`

## Requirements
- R1: After reset, every entry is GOOD and not denied, `sel_valid_o` and `probe_o` are low, and the first index granted is 0.
- R2: A request sampled at a rising edge, with at least one eligible entry, raises `sel_valid_o` for one cycle after that edge. `sel_idx_o` is the first eligible index after the last granted index, wrapping from N-1 to 0.
- R3: An entry is eligible only when its state is GOOD (internal encoding GOOD=0, SKIP=1, BAD=2) and it is not denied. No other entry is ever granted.
- R4: A feedback event of kind 0 (ECN mark), 1 (trimmed header) or 2 (NACK) moves a GOOD or SKIP entry to SKIP and restarts its round count. A BAD entry is not changed by these kinds.
- R5: A feedback event of kind 3 (timeout) moves the entry to BAD from any state. The entry is not granted from the next edge on, and every other eligible entry keeps being granted.
- R6: A feedback event of kind 4 (probe success) returns a BAD entry to GOOD. It has no effect on a GOOD or SKIP entry. Kinds 5 to 7 are ignored.
- R7: A SKIP entry returns to GOOD after `cfg_skip_rounds_i` round events with no new congestion feedback; a value of 0 acts as 1. A round event is either a grant whose index is not greater than the previously granted index, or a cycle in which a request is waiting and no entry is eligible.
- R8: When no entry is eligible, `sel_valid_o` stays low and one request is held. The held request is granted at the first edge at which an entry is eligible. A request that arrives while one is held merges with it.
- R9: A probe interval lasts `cfg_probe_ivl_i` cycles (at least N). At the end of each interval a sweep visits the indices 0 to N-1, one per cycle. `probe_o` is high, with `probe_idx_o` equal to the visited index, in each cycle that visits a BAD entry.
- R10: `deny_we_i` with `deny_set_i`=1 denies entry `deny_idx_i`, and with `deny_set_i`=0 clears the denial, from the next edge on. A denied entry is never granted. Its health state and its probing go on unchanged.
- R11: Selection at an edge uses the entry states that held before that edge. Feedback sampled at the same edge affects only later selections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Per-packet selection request strobe |
| sel_valid_o | output | 1 | Chosen index valid |
| sel_idx_o | output | IDX_W | Chosen entry index |
| fb_valid_i | input | 1 | Feedback event strobe |
| fb_kind_i | input | 3 | Feedback kind: 0 ECN, 1 trim, 2 NACK, 3 timeout, 4 probe success |
| fb_idx_i | input | IDX_W | Entry index that the feedback refers to |
| deny_we_i | input | 1 | Denylist write strobe |
| deny_set_i | input | 1 | 1 denies the entry, 0 clears the denial |
| deny_idx_i | input | IDX_W | Entry index for the denylist write |
| cfg_skip_rounds_i | input | RND_W | Rounds a SKIP entry waits before it becomes GOOD |
| cfg_probe_ivl_i | input | TMR_W | Probe interval in cycles |
| probe_o | output | 1 | Probe request pulse |
| probe_idx_o | output | IDX_W | Entry to be probed |

## Verification
Grants are registered. A request sampled at edge k shows up on `sel_valid_o` and `sel_idx_o` after edge k, and feedback or denylist writes sampled at edge k first change the grant decided at edge k+1. Probe pulses follow the committed table and sweep state, so a probe success turns off that entry's probe pulse from the cycle after its edge. The bench drives inputs at the falling edge and advances a reference model by exactly one rising edge per step. It compares every output at the following falling edge, so each result is checked in the cycle in which it is due.

// File: rtl/mp_path_pkg.sv
package mp_path_pkg;
  typedef enum logic [1:0] {
    PS_GOOD = 2'd0,
    PS_SKIP = 2'd1,
    PS_BAD  = 2'd2
  } path_st_e;

  localparam logic [2:0] FB_ECN   = 3'd0;
  localparam logic [2:0] FB_TRIM  = 3'd1;
  localparam logic [2:0] FB_NACK  = 3'd2;
  localparam logic [2:0] FB_TMO   = 3'd3;
  localparam logic [2:0] FB_PRBOK = 3'd4;
endpackage

// File: rtl/mp_entry_table.sv
module mp_entry_table
  import mp_path_pkg::*;
#(
  parameter int N     = 16,
  parameter int RND_W = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             round_i,
  input  logic [RND_W-1:0] cfg_rounds_i,
  input  logic             fb_valid_i,
  input  logic [2:0]       fb_kind_i,
  input  logic [IDX_W-1:0] fb_idx_i,
  input  logic             deny_we_i,
  input  logic             deny_set_i,
  input  logic [IDX_W-1:0] deny_idx_i,
  output logic [N-1:0]     elig_o,
  output logic [N-1:0]     bad_o
);
  logic [RND_W:0] lim;
  assign lim = (cfg_rounds_i == '0) ? (RND_W+1)'(1) : {1'b0, cfg_rounds_i};

  logic congest;
  assign congest = (fb_kind_i == FB_ECN) || (fb_kind_i == FB_TRIM) || (fb_kind_i == FB_NACK);

  for (genvar g = 0; g < N; g++) begin : g_ent
    path_st_e         st_q, st_d;
    logic [RND_W-1:0] cnt_q, cnt_d;
    logic [RND_W:0]   cnt_inc;
    logic             den_q;
    logic             hit;

    assign hit     = fb_valid_i && (fb_idx_i == IDX_W'(g));
    assign cnt_inc = {1'b0, cnt_q} + (RND_W+1)'(1);

    always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      // R7: round aging of a parked entry
      if (st_q == PS_SKIP && round_i) begin
        if (cnt_inc >= lim) begin
          st_d  = PS_GOOD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc[RND_W-1:0];
        end
      end
      // feedback overrides aging for its own entry
      if (hit) begin
        if (congest && st_q != PS_BAD) begin
          st_d  = PS_SKIP;
          cnt_d = '0;
        end else if (fb_kind_i == FB_TMO) begin
          st_d  = PS_BAD;
          cnt_d = '0;
        end else if (fb_kind_i == FB_PRBOK && st_q == PS_BAD) begin
          st_d  = PS_GOOD;
          cnt_d = '0;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= PS_GOOD;
        cnt_q <= '0;
        den_q <= 1'b0;
      end else begin
        st_q  <= st_d;
        cnt_q <= cnt_d;
        if (deny_we_i && deny_idx_i == IDX_W'(g)) den_q <= deny_set_i;
      end
    end

    assign elig_o[g] = (st_q == PS_GOOD) && !den_q;
    assign bad_o[g]  = (st_q == PS_BAD);
  end
endmodule

// File: rtl/mp_rr_pick.sv
module mp_rr_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     elig_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wrap_o
);
  logic [IDX_W-1:0] cand;

  // descending scan: the nearest index after last_i is written last
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    cand  = '0;
    for (int k = N; k >= 1; k--) begin
      cand = IDX_W'((int'(last_i) + k) % N);
      if (elig_i[cand]) begin
        any_o = 1'b1;
        idx_o = cand;
      end
    end
  end

  assign wrap_o = (idx_o <= last_i);
endmodule

// File: rtl/mp_probe_sched.sv
module mp_probe_sched #(
  parameter int N     = 16,
  parameter int IDX_W = 4,
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] cfg_ivl_i,
  input  logic [N-1:0]     bad_i,
  output logic             probe_o,
  output logic [IDX_W-1:0] probe_idx_o
);
  logic [TMR_W-1:0] tmr_q;
  logic             sweep_q;
  logic [IDX_W-1:0] scan_q;
  logic             expire;

  assign expire = ({1'b0, tmr_q} + (TMR_W+1)'(1)) >= {1'b0, cfg_ivl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q   <= '0;
      sweep_q <= 1'b0;
      scan_q  <= '0;
    end else begin
      tmr_q <= expire ? '0 : tmr_q + TMR_W'(1);
      if (expire) begin
        sweep_q <= 1'b1;
        scan_q  <= '0;
      end else if (sweep_q) begin
        if (scan_q == IDX_W'(N-1)) sweep_q <= 1'b0;
        else                       scan_q  <= scan_q + IDX_W'(1);
      end
    end
  end

  assign probe_o     = sweep_q && bad_i[scan_q];
  assign probe_idx_o = scan_q;
endmodule

// File: rtl/mp_path_sel.sv
module mp_path_sel #(
  parameter int  N_PATH = 16,
  parameter int  RND_W  = 4,
  parameter int  TMR_W  = 16,
  localparam int IDX_W  = $clog2(N_PATH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             sel_valid_o,
  output logic [IDX_W-1:0] sel_idx_o,
  input  logic             fb_valid_i,
  input  logic [2:0]       fb_kind_i,
  input  logic [IDX_W-1:0] fb_idx_i,
  input  logic             deny_we_i,
  input  logic             deny_set_i,
  input  logic [IDX_W-1:0] deny_idx_i,
  input  logic [RND_W-1:0] cfg_skip_rounds_i,
  input  logic [TMR_W-1:0] cfg_probe_ivl_i,
  output logic             probe_o,
  output logic [IDX_W-1:0] probe_idx_o
);
  logic [N_PATH-1:0] elig_vec, bad_vec;
  logic              pend_q, want, any, wrap, grant, round;
  logic [IDX_W-1:0]  pick, last_q, idx_q;
  logic              vld_q;

  assign want  = req_i || pend_q;
  assign grant = want && any;
  // R7: a wrapping grant or a starved request closes a round
  assign round = grant ? wrap : want;

  mp_rr_pick #(.N(N_PATH), .IDX_W(IDX_W)) u_pick (
    .elig_i (elig_vec),
    .last_i (last_q),
    .any_o  (any),
    .idx_o  (pick),
    .wrap_o (wrap)
  );

  mp_entry_table #(.N(N_PATH), .RND_W(RND_W), .IDX_W(IDX_W)) u_tab (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .round_i      (round),
    .cfg_rounds_i (cfg_skip_rounds_i),
    .fb_valid_i   (fb_valid_i),
    .fb_kind_i    (fb_kind_i),
    .fb_idx_i     (fb_idx_i),
    .deny_we_i    (deny_we_i),
    .deny_set_i   (deny_set_i),
    .deny_idx_i   (deny_idx_i),
    .elig_o       (elig_vec),
    .bad_o        (bad_vec)
  );

  mp_probe_sched #(.N(N_PATH), .IDX_W(IDX_W), .TMR_W(TMR_W)) u_prb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_ivl_i   (cfg_probe_ivl_i),
    .bad_i       (bad_vec),
    .probe_o     (probe_o),
    .probe_idx_o (probe_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= IDX_W'(N_PATH-1);
      pend_q <= 1'b0;
    end else begin
      vld_q  <= grant;
      pend_q <= want && !any;
      if (grant) begin
        idx_q  <= pick;
        last_q <= pick;
      end
    end
  end

  assign sel_valid_o = vld_q;
  assign sel_idx_o   = idx_q;
endmodule

// File: rtl/mp_path_sel_chk.sv
module mp_path_sel_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             pend_q,
  input logic             sel_valid_o,
  input logic [IDX_W-1:0] sel_idx_o,
  input logic             fb_valid_i,
  input logic [2:0]       fb_kind_i,
  input logic [IDX_W-1:0] fb_idx_i,
  input logic             deny_we_i,
  input logic             deny_set_i,
  input logic [IDX_W-1:0] deny_idx_i,
  input logic [N-1:0]     elig_vec,
  input logic [N-1:0]     bad_vec
);
  logic [N-1:0] elig_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_d <= '0;
    else         elig_d <= elig_vec;
  end

  a_r2_grant_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i || pend_q) && (elig_vec != '0) |=> sel_valid_o);

  a_r3_grant_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> elig_d[sel_idx_o]);

  a_r4_congest_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_valid_i && (fb_kind_i <= 3'd2) && !bad_vec[fb_idx_i] |=> !elig_vec[$past(fb_idx_i)]);

  a_r5_timeout_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_valid_i && (fb_kind_i == 3'd3) |=> bad_vec[$past(fb_idx_i)]);

  a_r6_probe_heals: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_valid_i && (fb_kind_i == 3'd4) && bad_vec[fb_idx_i] |=> !bad_vec[$past(fb_idx_i)]);

  a_r8_starved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i || pend_q) && (elig_vec == '0) |=> !sel_valid_o && pend_q);

  a_r10_deny_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_we_i && deny_set_i |=> !elig_vec[$past(deny_idx_i)]);
endmodule

bind mp_path_sel mp_path_sel_chk #(.N(N_PATH), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .pend_q      (pend_q),
  .sel_valid_o (sel_valid_o),
  .sel_idx_o   (sel_idx_o),
  .fb_valid_i  (fb_valid_i),
  .fb_kind_i   (fb_kind_i),
  .fb_idx_i    (fb_idx_i),
  .deny_we_i   (deny_we_i),
  .deny_set_i  (deny_set_i),
  .deny_idx_i  (deny_idx_i),
  .elig_vec    (elig_vec),
  .bad_vec     (bad_vec)
);

// File: tb/mp_path_sel_tb_top.sv
`timescale 1ns/1ps
module mp_path_sel_tb_top;
  localparam int N = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       sel_valid_o;
  logic [3:0] sel_idx_o;
  logic       fb_valid_i = 1'b0;
  logic [2:0] fb_kind_i = '0;
  logic [3:0] fb_idx_i = '0;
  logic       deny_we_i = 1'b0;
  logic       deny_set_i = 1'b0;
  logic [3:0] deny_idx_i = '0;
  logic [3:0] cfg_skip_rounds_i = 4'd3;
  logic [15:0] cfg_probe_ivl_i = 16'd40;
  logic       probe_o;
  logic [3:0] probe_idx_o;

  always #10 clk_i = ~clk_i;

  mp_path_sel dut_i (.*);

  int n_run = 0, n_fail = 0;
  string tag = "R1";
  bit done = 0;

  // reference model
  int m_st[N], m_cnt[N], m_den[N];
  int m_last = N-1, m_pend = 0, m_tmr = 0, m_sweep = 0, m_scan = 0, m_val = 0, m_idx = 0;

  task automatic chk(bit ok, string t, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic int eligible(int i);
    return (m_st[i] == 0 && m_den[i] == 0) ? 1 : 0;
  endfunction

  task automatic tick();
    int ns[N], nc[N];
    int pick, want, rnd, lim, nval, nidx, nlast, npend, ntmr, nsw, nsc, fi;
    bit ep;
    want = (req_i || m_pend != 0) ? 1 : 0;
    pick = -1;
    for (int k = 1; k <= N; k++) begin
      if (pick < 0 && eligible((m_last + k) % N) != 0) pick = (m_last + k) % N;
    end
    nidx = m_idx; nlast = m_last;
    if (want != 0 && pick >= 0) begin
      nval = 1; nidx = pick; rnd = (pick <= m_last) ? 1 : 0; nlast = pick; npend = 0;
    end else begin
      nval = 0; npend = want; rnd = want;
    end
    lim = (cfg_skip_rounds_i == 0) ? 1 : int'(cfg_skip_rounds_i);
    for (int i = 0; i < N; i++) begin
      ns[i] = m_st[i]; nc[i] = m_cnt[i];
      if (m_st[i] == 1 && rnd != 0) begin
        if (m_cnt[i] + 1 >= lim) begin ns[i] = 0; nc[i] = 0; end
        else nc[i] = m_cnt[i] + 1;
      end
    end
    if (fb_valid_i) begin
      fi = int'(fb_idx_i);
      if (fb_kind_i <= 2) begin
        if (m_st[fi] != 2) begin ns[fi] = 1; nc[fi] = 0; end
      end else if (fb_kind_i == 3) begin
        ns[fi] = 2; nc[fi] = 0;
      end else if (fb_kind_i == 4 && m_st[fi] == 2) begin
        ns[fi] = 0; nc[fi] = 0;
      end
    end
    nsw = m_sweep; nsc = m_scan;
    if (m_tmr + 1 >= int'(cfg_probe_ivl_i)) begin
      ntmr = 0; nsw = 1; nsc = 0;
    end else begin
      ntmr = m_tmr + 1;
      if (m_sweep != 0) begin
        if (m_scan == N-1) nsw = 0; else nsc = m_scan + 1;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    if (deny_we_i) m_den[deny_idx_i] = deny_set_i ? 1 : 0;
    for (int i = 0; i < N; i++) begin m_st[i] = ns[i]; m_cnt[i] = nc[i]; end
    m_val = nval; m_idx = nidx; m_last = nlast; m_pend = npend;
    m_tmr = ntmr; m_sweep = nsw; m_scan = nsc;
    chk(sel_valid_o == (m_val != 0), {tag, " sel_valid"}, int'(sel_valid_o), m_val);
    if (m_val != 0) chk(int'(sel_idx_o) == m_idx, {tag, " sel_idx"}, int'(sel_idx_o), m_idx);
    ep = (m_sweep != 0) && (m_st[m_scan] == 2);
    chk(probe_o == ep, "R9 probe", int'(probe_o), int'(ep));
    if (ep) chk(int'(probe_idx_o) == m_scan, "R9 probe_idx", int'(probe_idx_o), m_scan);
    req_i = 1'b0; fb_valid_i = 1'b0; deny_we_i = 1'b0;
  endtask

  task automatic do_req();
    req_i = 1'b1; tick();
  endtask

  task automatic do_fb(int kind, int idx);
    fb_valid_i = 1'b1; fb_kind_i = 3'(kind); fb_idx_i = 4'(idx); tick();
  endtask

  task automatic do_deny(bit set, int idx);
    deny_we_i = 1'b1; deny_set_i = set; deny_idx_i = 4'(idx); tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int c2, c3, c5, p0, p9;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin m_st[i] = 0; m_cnt[i] = 0; m_den[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state
    chk(!sel_valid_o, "R1 valid after reset", int'(sel_valid_o), 0);
    chk(!probe_o, "R1 probe after reset", int'(probe_o), 0);
    tag = "R1";
    do_req();
    chk(sel_valid_o && sel_idx_o == 4'd0, "R1 first grant", int'(sel_idx_o), 0);
    tag = "R2";
    do_req();
    chk(sel_valid_o && sel_idx_o == 4'd1, "R2 round-robin", int'(sel_idx_o), 1);
    tag = "R5";
    do_fb(3, 2);
    do_req();
    chk(sel_valid_o && sel_idx_o == 4'd3, "R5 timeout skipped", int'(sel_idx_o), 3);
    tag = "R10";
    do_deny(1'b1, 3);
    do_req();
    chk(sel_valid_o && sel_idx_o == 4'd4, "R10 denied skipped", int'(sel_idx_o), 4);
    tag = "R4";
    do_fb(0, 5);
    do_req();
    chk(sel_valid_o && sel_idx_o == 4'd6, "R4 ecn skipped", int'(sel_idx_o), 6);
    tag = "R6";
    do_fb(4, 5);
    do_req();
    chk(sel_valid_o && sel_idx_o == 4'd7, "R6 probe ok on skip ignored", int'(sel_idx_o), 7);
    tag = "R11";
    req_i = 1'b1; do_fb(3, 8);
    chk(sel_valid_o && sel_idx_o == 4'd8, "R11 same-edge feedback", int'(sel_idx_o), 8);
    do_req();
    chk(sel_valid_o && sel_idx_o == 4'd9, "R11 later grant", int'(sel_idx_o), 9);
    tag = "R7";
    c2 = 0; c3 = 0; c5 = 0;
    for (int n = 0; n < 80; n++) begin
      do_req();
      if (sel_valid_o && sel_idx_o == 4'd2) c2++;
      if (sel_valid_o && sel_idx_o == 4'd3) c3++;
      if (sel_valid_o && sel_idx_o == 4'd5) c5++;
    end
    chk(c5 > 0, "R7 skip entry returns", c5, 1);
    chk(c2 == 0, "R5 bad entry never granted", c2, 0);
    chk(c3 == 0, "R10 denied entry never granted", c3, 0);
    tag = "R8";
    for (int i = 0; i < N; i++) do_fb(3, i);
    do_req();
    chk(!sel_valid_o, "R8 starved hold", int'(sel_valid_o), 0);
    req_i = 1'b1; tick();
    repeat (4) tick();
    chk(!sel_valid_o, "R8 still held", int'(sel_valid_o), 0);
    do_fb(4, 9);
    chk(!sel_valid_o, "R8 not yet granted", int'(sel_valid_o), 0);
    tick();
    chk(sel_valid_o && sel_idx_o == 4'd9, "R8 held request granted", int'(sel_idx_o), 9);
    tick();
    chk(!sel_valid_o, "R8 merged request single grant", int'(sel_valid_o), 0);
    tag = "R9";
    p0 = 0; p9 = 0;
    for (int n = 0; n < 100; n++) begin
      tick();
      if (probe_o && probe_idx_o == 4'd0) p0++;
      if (probe_o && probe_idx_o == 4'd9) p9++;
    end
    chk(p0 >= 2, "R9 bad entry probed each interval", p0, 2);
    chk(p9 == 0, "R9 good entry not probed", p9, 0);
    do_deny(1'b0, 3);
    for (int i = 0; i < N; i++) do_fb(4, i);
    tag = "R3";
    for (int n = 0; n < 4000; n++) begin
      req_i = ($urandom % 2) == 0;
      if ($urandom % 5 == 0) begin
        fb_valid_i = 1'b1; fb_kind_i = 3'($urandom % 6); fb_idx_i = 4'($urandom % N);
      end
      if ($urandom % 25 == 0) begin
        deny_we_i = 1'b1; deny_set_i = 1'($urandom % 2); deny_idx_i = 4'($urandom % N);
      end
      if (n == 2000) cfg_skip_rounds_i = 4'd0;
      tick();
    end
    finish_run();
  end
endmodule